// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Arbiter

This block keeps one pending flag for each of seven interrupt sources and picks one of them to hand to the processor whenever the core asks. The choice follows a fixed priority chain. That chain changes shape with the privilege mode held in a hyper-state register, and it is gated by the interrupt-enable bit. In the most privileged mode, only the hyper timer match and interrupt vector sources are eligible, and both need enable set. In the other modes, a trap-level-zero event and the hyper timer match bypass the enable bit. The remaining sources wait for enable.

Software interrupt levels arrive as a 16-bit vector. A priority encoder reduces the vector to a level, the highest set bit among bits 15 down to 1. A software interrupt is delivered only when that level is above the processor interrupt level. A pending interrupt vector displaces a software interrupt whose level is below 6. A delivery happens in the cycle after a request. It clears the winner's flag and decrements a pending counter. The one exception is a software interrupt that still has other level bits set: its flag stays set. The block also holds the hyper-state register, whose identification bit always reads back as 1. It flags a rising edge of the enable bit so that the core re-examines pending work.

Top module: `irq_prio_arb`

## Requirements
- R1: A post with a code from 0 to 6 sets that source's pending flag and increments the pending count by one, even when the flag is already set. The count saturates at its maximum (15 by default). Source codes are: trap-level-zero 0, hyper timer match 1, interrupt vector 2, cpu queue 3, device queue 4, resumable error 5, software interrupt 6.
- R2: A post with code 7 changes no flag and no count. It drives `post_err_o` high for exactly one cycle, in the cycle after the post.
- R3: `any_pend_o` is high exactly when the pending count is nonzero.
- R4: A request is answered in the following cycle on `irq_vld_o`, `irq_code_o` and `irq_lvl_o`. A delivery clears the winner's flag and decrements the count. A request that finds nothing deliverable leaves `irq_vld_o` low and leaves every flag and the count unchanged.
- R5: With hyper-state bit 2 set, only hyper timer match (first) and then interrupt vector can be delivered, and only while `ie_i` is high.
- R6: With hyper-state bit 2 clear, trap-level-zero has top priority. It is delivered only when hyper-state bit 0 is set and `tl_i` is 0.
- R7: With hyper-state bit 2 clear, hyper timer match comes next and is delivered whatever the value of `ie_i`.
- R8: With hyper-state bit 2 clear and `ie_i` high, the remaining order is cpu queue, device queue, software interrupt, resumable error. With `ie_i` low, none of these is delivered.
- R9: In the mode of R8, when the software interrupt is pending, its level is below 6 and an interrupt vector is pending, the interrupt vector is delivered instead. An interrupt vector is never delivered in this mode unless a software interrupt is also pending.
- R10: The software level is the index of the highest set bit among softint bits 15..1, and bit 0 is ignored. A software interrupt is delivered, with that level on `irq_lvl_o`, only when the level exceeds `pil_i`. Otherwise the chain falls through to resumable error.
- R11: A delivered software interrupt keeps its flag, and leaves the count unchanged, while softint bits 15..1 other than the delivered level remain set.
- R12: The hyper-state register resets to 0x800 and loads `hp_wdata_i` on `hp_we_i`. Bit 11 is forced to 1. Bit 2 selects the hyperprivileged mode and bit 0 enables trap-level-zero.
- R13: A low-to-high change of `ie_i` produces a one-cycle pulse on `recheck_o` in the cycle after it is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld_i | input | 1 | Post strobe |
| post_code_i | input | 3 | Source code being posted |
| req_i | input | 1 | Ask for one interrupt |
| ie_i | input | 1 | Interrupt-enable bit of the processor state |
| hp_we_i | input | 1 | Hyper-state register write enable |
| hp_wdata_i | input | 12 | Hyper-state write data |
| tl_i | input | 3 | Current trap level |
| pil_i | input | 4 | Processor interrupt level |
| softint_i | input | 16 | Software interrupt level bits |
| irq_vld_o | output | 1 | Interrupt delivered this cycle |
| irq_code_o | output | 3 | Code of the delivered source |
| irq_lvl_o | output | 4 | Software level of a delivered software interrupt, else 0 |
| any_pend_o | output | 1 | Pending count nonzero |
| pend_cnt_o | output | 4 | Pending count |
| post_err_o | output | 1 | Out-of-range post seen |
| recheck_o | output | 1 | Enable just rose |
| hpstate_o | output | 12 | Hyper-state register |

## Verification
The bench targets the level boundary at 5 versus 6. A design with an off-by-one there would let the interrupt vector win at level 6, or lose it at level 5. It also probes the `pil_i` equality case, where a `>=` comparison would deliver a software interrupt that should fall through to resumable error. Further cases are:
- an interrupt vector pending alone outside hyperprivileged mode, which a flattened priority chain would wrongly deliver;
- a software interrupt with a second level bit still set, where clearing the flag too early would lose the remaining level;
- repeated posts of one source, where a count that tracks flags instead of posts would disagree with the expected count and any-pending result.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NSRC   = 7;
    localparam int SRC_W  = 3;

    // Source codes; numeric values are visible on the ports
    typedef enum logic [SRC_W-1:0] {
        SRC_TLZ  = 3'd0,
        SRC_HTM  = 3'd1,
        SRC_IVEC = 3'd2,
        SRC_CPUQ = 3'd3,
        SRC_DEVQ = 3'd4,
        SRC_RERR = 3'd5,
        SRC_SOFT = 3'd6
    } irq_src_e;

    // Hyper-state bit positions
    localparam int HS_TLZ_BIT  = 0;
    localparam int HS_HYP_BIT  = 2;
    localparam int HS_ID_BIT   = 11;

    // Software levels below this one yield to a pending interrupt vector
    localparam int IVEC_CUT_LVL = 6;

endpackage

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc #(
    parameter int W  = 16,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [LW-1:0] lvl_o
);
    // Highest set bit among W-1..1; bit 0 carries no level
    always_comb begin
        lvl_o = '0;
        for (int i = 1; i < W; i++) begin
            if (vec_i[i]) lvl_o = LW'(i);
        end
    end
endmodule

// File: rtl/irq_sel.sv
module irq_sel
    import irq_arb_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    input  logic            req_i,
    input  logic            hyper_i,
    input  logic            ie_i,
    input  logic            tlz_en_i,
    input  logic            tl_zero_i,
    input  logic            lvl_gt_pil_i,
    input  logic            lvl_low_i,
    input  logic            soft_more_i,
    output logic            hit_o,
    output irq_src_e        code_o,
    output logic [NSRC-1:0] clr_o
);
    irq_src_e pick;
    logic     found;

    always_comb begin
        found = 1'b0;
        pick  = SRC_TLZ;
        if (hyper_i) begin
            if (ie_i) begin
                if (pend_i[SRC_HTM]) begin
                    found = 1'b1; pick = SRC_HTM;
                end else if (pend_i[SRC_IVEC]) begin
                    found = 1'b1; pick = SRC_IVEC;
                end
            end
        end else begin
            if (pend_i[SRC_TLZ] && tlz_en_i && tl_zero_i) begin
                found = 1'b1; pick = SRC_TLZ;
            end else if (pend_i[SRC_HTM]) begin
                found = 1'b1; pick = SRC_HTM;
            end else if (ie_i) begin
                if (pend_i[SRC_CPUQ]) begin
                    found = 1'b1; pick = SRC_CPUQ;
                end else if (pend_i[SRC_DEVQ]) begin
                    found = 1'b1; pick = SRC_DEVQ;
                end else if (pend_i[SRC_SOFT] && lvl_low_i && pend_i[SRC_IVEC]) begin
                    found = 1'b1; pick = SRC_IVEC;
                end else if (pend_i[SRC_SOFT] && lvl_gt_pil_i) begin
                    found = 1'b1; pick = SRC_SOFT;
                end else if (pend_i[SRC_RERR]) begin
                    found = 1'b1; pick = SRC_RERR;
                end
            end
        end
    end

    always_comb begin
        hit_o  = req_i && found;
        code_o = pick;
        clr_o  = '0;
        if (hit_o && !(pick == SRC_SOFT && soft_more_i)) begin
            clr_o = NSRC'(1) << pick;
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_arb_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int SI_W  = 16,
    parameter int TL_W  = 3,
    parameter int HPS_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     post_vld_i,
    input  logic [SRC_W-1:0]         post_code_i,
    input  logic                     req_i,
    input  logic                     ie_i,
    input  logic                     hp_we_i,
    input  logic [HPS_W-1:0]         hp_wdata_i,
    input  logic [TL_W-1:0]          tl_i,
    input  logic [$clog2(SI_W)-1:0]  pil_i,
    input  logic [SI_W-1:0]          softint_i,
    output logic                     irq_vld_o,
    output logic [SRC_W-1:0]         irq_code_o,
    output logic [$clog2(SI_W)-1:0]  irq_lvl_o,
    output logic                     any_pend_o,
    output logic [CNT_W-1:0]         pend_cnt_o,
    output logic                     post_err_o,
    output logic                     recheck_o,
    output logic [HPS_W-1:0]         hpstate_o
);
    localparam int LVL_W = $clog2(SI_W);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [HPS_W-1:0] ID_MASK = HPS_W'(1) << HS_ID_BIT;

    typedef struct packed {
        logic [NSRC-1:0]  pend;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        irq_src_e         code;
        logic [LVL_W-1:0] lvl;
        logic             err;
        logic             ie_prev;
        logic             recheck;
        logic [HPS_W-1:0] hps;
    } state_t;

    state_t st_d, st_q;

    logic [LVL_W-1:0] soft_lvl;
    logic [SI_W-1:0]  soft_rest;
    logic             soft_more;
    logic             sel_hit;
    irq_src_e         sel_code;
    logic [NSRC-1:0]  sel_clr;
    logic [NSRC-1:0]  post_set;
    logic             inc, dec, bad_post;

    irq_lvl_enc #(.W(SI_W), .LW(LVL_W)) u_lvl (
        .vec_i (softint_i),
        .lvl_o (soft_lvl)
    );

    always_comb begin
        soft_rest = softint_i & ~(SI_W'(1) << soft_lvl);
        soft_more = |soft_rest[SI_W-1:1];
    end

    irq_sel u_sel (
        .pend_i       (st_q.pend),
        .req_i        (req_i),
        .hyper_i      (st_q.hps[HS_HYP_BIT]),
        .ie_i         (ie_i),
        .tlz_en_i     (st_q.hps[HS_TLZ_BIT]),
        .tl_zero_i    (tl_i == '0),
        .lvl_gt_pil_i (soft_lvl > pil_i),
        .lvl_low_i    (soft_lvl < LVL_W'(IVEC_CUT_LVL)),
        .soft_more_i  (soft_more),
        .hit_o        (sel_hit),
        .code_o       (sel_code),
        .clr_o        (sel_clr)
    );

    always_comb begin
        st_d     = st_q;
        bad_post = post_vld_i && (int'(post_code_i) >= NSRC);
        post_set = (post_vld_i && !bad_post) ? (NSRC'(1) << post_code_i) : '0;
        inc      = |post_set;
        dec      = |(st_q.pend & sel_clr);

        st_d.pend = (st_q.pend & ~sel_clr) | post_set;
        if (inc && !dec) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (dec && !inc) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end

        st_d.vld     = sel_hit;
        st_d.code    = sel_code;
        st_d.lvl     = (sel_hit && sel_code == SRC_SOFT) ? soft_lvl : '0;
        st_d.err     = bad_post;
        st_d.ie_prev = ie_i;
        st_d.recheck = ie_i && !st_q.ie_prev;
        if (hp_we_i) st_d.hps = hp_wdata_i | ID_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.hps     <= ID_MASK;
        end else begin
            st_q         <= st_d;
        end
    end

    assign irq_vld_o  = st_q.vld;
    assign irq_code_o = st_q.code;
    assign irq_lvl_o  = st_q.lvl;
    assign any_pend_o = (st_q.cnt != '0);
    assign pend_cnt_o = st_q.cnt;
    assign post_err_o = st_q.err;
    assign recheck_o  = st_q.recheck;
    assign hpstate_o  = st_q.hps;

    // R4
    deliver_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vld_o |-> |($past(st_q.pend) & (NSRC'(1) << irq_code_o)));

    // R4
    no_req_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> !irq_vld_o);

    // R5
    hyper_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vld_o && $past(st_q.hps[HS_HYP_BIT])) |->
        ($past(ie_i) && (irq_code_o == SRC_HTM || irq_code_o == SRC_IVEC)));

    // R2
    bad_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_err_o |-> ($past(post_vld_i) && $past(post_code_i) == 3'd7));

    // R4
    idle_req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) && !irq_vld_o && !$past(post_vld_i)) |-> $stable(st_q.pend));

    // R13
    recheck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recheck_o |-> ($past(ie_i) && !$past(st_q.ie_prev)));
endmodule

// File: tb/irq_prio_arb_bench.sv
`timescale 1ns/1ps
module irq_prio_arb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_vld = 1'b0;
    logic [2:0]  post_code = '0;
    logic        req = 1'b0;
    logic        ie = 1'b0;
    logic        hp_we = 1'b0;
    logic [11:0] hp_wdata = '0;
    logic [2:0]  tl = '0;
    logic [3:0]  pil = '0;
    logic [15:0] softint = '0;
    logic        irq_vld, any_pend, post_err, recheck;
    logic [2:0]  irq_code;
    logic [3:0]  irq_lvl, pend_cnt;
    logic [11:0] hpstate;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_prio_arb u_irq_prio_arb (
        .clk(clk), .rst_n(rst_n), .post_vld_i(post_vld), .post_code_i(post_code),
        .req_i(req), .ie_i(ie), .hp_we_i(hp_we), .hp_wdata_i(hp_wdata), .tl_i(tl),
        .pil_i(pil), .softint_i(softint), .irq_vld_o(irq_vld), .irq_code_o(irq_code),
        .irq_lvl_o(irq_lvl), .any_pend_o(any_pend), .pend_cnt_o(pend_cnt),
        .post_err_o(post_err), .recheck_o(recheck), .hpstate_o(hpstate)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        hp;
        logic        ien;
        logic        tlz;
        logic [2:0]  tlv;
        logic [3:0]  pl;
        logic [15:0] si;
        logic [6:0]  mask;  // bit n = source code n
        logic        evld;
        logic [2:0]  ecode;
        logic [3:0]  elvl;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd5,  1'b1,1'b1,1'b0,3'd0,4'd0,16'h0000,7'h0E,1'b1,3'd1,4'd0}, // R5 timer first
        '{4'd5,  1'b1,1'b1,1'b0,3'd0,4'd0,16'h0000,7'h2C,1'b1,3'd2,4'd0}, // R5 vector next
        '{4'd5,  1'b1,1'b0,1'b0,3'd0,4'd0,16'h0000,7'h06,1'b0,3'd0,4'd0}, // R5 ie low
        '{4'd6,  1'b0,1'b0,1'b1,3'd0,4'd0,16'h0000,7'h03,1'b1,3'd0,4'd0}, // R6 tlz wins
        '{4'd6,  1'b0,1'b0,1'b1,3'd2,4'd0,16'h0000,7'h03,1'b1,3'd1,4'd0}, // R6 tl nonzero
        '{4'd6,  1'b0,1'b0,1'b0,3'd0,4'd0,16'h0000,7'h03,1'b1,3'd1,4'd0}, // R6 tlz disabled
        '{4'd7,  1'b0,1'b0,1'b0,3'd0,4'd0,16'h0000,7'h0A,1'b1,3'd1,4'd0}, // R7 timer no ie
        '{4'd8,  1'b0,1'b0,1'b0,3'd0,4'd0,16'h0000,7'h28,1'b0,3'd0,4'd0}, // R8 ie gates
        '{4'd8,  1'b0,1'b1,1'b0,3'd0,4'd0,16'h0200,7'h78,1'b1,3'd3,4'd0}, // R8 cpu queue
        '{4'd8,  1'b0,1'b1,1'b0,3'd0,4'd0,16'h0200,7'h70,1'b1,3'd4,4'd0}, // R8 device queue
        '{4'd10, 1'b0,1'b1,1'b0,3'd0,4'd3,16'h0200,7'h60,1'b1,3'd6,4'd9}, // R10 above pil
        '{4'd10, 1'b0,1'b1,1'b0,3'd0,4'd9,16'h0200,7'h60,1'b1,3'd5,4'd0}, // R10 equal pil
        '{4'd9,  1'b0,1'b1,1'b0,3'd0,4'd0,16'h0010,7'h44,1'b1,3'd2,4'd0}, // R9 low level
        '{4'd9,  1'b0,1'b1,1'b0,3'd0,4'd0,16'h0080,7'h44,1'b1,3'd6,4'd7}, // R9 high level
        '{4'd9,  1'b0,1'b1,1'b0,3'd0,4'd0,16'h0000,7'h04,1'b0,3'd0,4'd0}, // R9 vector alone
        '{4'd10, 1'b0,1'b1,1'b0,3'd0,4'd0,16'h0001,7'h40,1'b0,3'd0,4'd0}, // R10 bit0 ignored
        '{4'd5,  1'b1,1'b1,1'b0,3'd0,4'd0,16'h0200,7'h68,1'b0,3'd0,4'd0}, // R5 others barred
        '{4'd9,  1'b0,1'b1,1'b0,3'd0,4'd0,16'h0020,7'h44,1'b1,3'd2,4'd0}, // R9 level 5
        '{4'd9,  1'b0,1'b1,1'b0,3'd0,4'd0,16'h0040,7'h44,1'b1,3'd6,4'd6}  // R9 level 6
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic post(input logic [2:0] c);
        @(negedge clk); post_vld = 1'b1; post_code = c;
        @(negedge clk); post_vld = 1'b0;
    endtask

    task automatic write_hp(input logic [11:0] v);
        @(negedge clk); hp_we = 1'b1; hp_wdata = v;
        @(negedge clk); hp_we = 1'b0;
    endtask

    task automatic request();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R12 R3 reset state
        do_reset();
        chk("R12 reset hpstate", hpstate, 12'h800);
        chk("R3 reset any_pend", any_pend, 0);
        chk("R4 reset vld", irq_vld, 0);
        write_hp(12'h000);
        chk("R12 id bit forced", hpstate, 12'h800);
        write_hp(12'h005);
        chk("R12 write", hpstate, 12'h805);

        for (int k = 0; k < NV; k++) begin
            vec_t v = VECS[k];
            string tg = $sformatf("R%0d vec %0d", v.rq, k);
            do_reset();
            ie = v.ien; tl = v.tlv; pil = v.pl; softint = v.si;
            write_hp({9'd0, v.hp, 1'b0, v.tlz});
            for (int b = 0; b < 7; b++) if (v.mask[b]) post(3'(b));
            request();
            chk({tg, " vld"}, irq_vld, v.evld);
            if (v.evld) chk({tg, " code"}, irq_code, v.ecode);
            if (v.evld && v.ecode == 3'd6) chk({tg, " lvl"}, irq_lvl, v.elvl);
            chk({tg, " R4 count"}, pend_cnt, $countones(v.mask) - int'(v.evld));
        end

        // R1 R3 R4 repeated post, delivery, empty request
        do_reset(); ie = 1'b1; tl = '0; pil = '0; softint = '0;
        post(3'd3); post(3'd3);
        chk("R1 double post count", pend_cnt, 2);
        request();
        chk("R4 cpu delivered", irq_code, 3);
        chk("R4 count after", pend_cnt, 1);
        chk("R3 any_pend with count", any_pend, 1);
        request();
        chk("R4 nothing deliverable", irq_vld, 0);
        chk("R4 count unchanged", pend_cnt, 1);

        // R11 software flag kept while other levels remain
        do_reset(); ie = 1'b1; pil = '0; softint = 16'h0220;
        post(3'd6);
        request();
        chk("R11 first soft", irq_code, 6);
        chk("R11 first lvl", irq_lvl, 9);
        chk("R11 count kept", pend_cnt, 1);
        softint = 16'h0200;
        request();
        chk("R11 second soft vld", irq_vld, 1);
        chk("R11 count cleared", pend_cnt, 0);
        chk("R3 any_pend clear", any_pend, 0);

        // R2 out-of-range code
        @(negedge clk); post_vld = 1'b1; post_code = 3'd7;
        @(negedge clk); post_vld = 1'b0;
        chk("R2 err pulse", post_err, 1);
        chk("R2 count untouched", pend_cnt, 0);
        @(negedge clk);
        chk("R2 err one cycle", post_err, 0);

        // R1 saturation
        for (int i = 0; i < 16; i++) post(3'd5);
        chk("R1 saturate", pend_cnt, 15);

        // R13 enable edge
        do_reset(); ie = 1'b0;
        @(negedge clk); ie = 1'b1;
        @(negedge clk);
        chk("R13 pulse", recheck, 1);
        @(negedge clk);
        chk("R13 pulse ends", recheck, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule